// File: doc/BRIEF.md
# Paged Nibble Data Memory with Indexed Ports

This block is the data store of a small 4-bit controller. It holds six pages of 56 nibbles each, 336 nibbles in all, plus a window of eight nibble registers that every page shares. Each access is picked out by a 6-bit offset within the current page. The page register selects which page the offset refers to. Offsets 0 to 7 always land in the shared window, whatever the page. Offsets 8 to 63 land in the paged store.

The offset comes from one of three sources, chosen by a select input. A direct access takes the offset from the address input. Indexed port 0 builds the offset from two pointer fields: a 2-bit high part and a 4-bit low part. Indexed port 1 does the same from a second pair of fields. Whatever its source, the offset is combined with the current page. Reading is combinational from the stored state. A write takes effect at the next rising clock edge.

Top module: `paged_nibble_ram`

## Requirements
- R1: After reset the page register holds 0 and every shared register and every paged nibble reads 0.
- R2: When `page_ld` is 1 at a rising edge, the page register takes `page_in`. Otherwise it keeps its value. An access in the same cycle as a load uses the page held before the load.
- R3: An offset of 0 to 7 reads and writes shared register number equal to that offset. This holds on every page value, including 6 and 7.
- R4: With a direct access, an offset of 8 to 63 on page 0 to 5 reaches a nibble of its own. Writing one (page, offset) pair changes no other pair.
- R5: Select encoding: 0 means direct, 1 means indexed port 0, 2 means indexed port 1, and 3 behaves as direct. With select 1 the offset is {`ptr1`, `ptr0`}, with `ptr1` as bits 5:4.
- R6: With select 2 the offset is {`ptr3`, `ptr2`}, with `ptr3` as bits 5:4. The address input is ignored for both indexed selects.
- R7: When the page register holds 6 or 7, accesses to offsets 8 to 63 read 0 and their writes change nothing.
- R8: `rdata` shows the addressed nibble in the same cycle, with no register stage. A value written at an edge is visible from the cycle after that edge, and during the write cycle `rdata` still shows the old content.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| page_ld | input | 1 | Load the page register from `page_in` |
| page_in | input | 3 | New page value |
| wr_en | input | 1 | 1 writes `wdata` to the addressed nibble; 0 reads only |
| sel | input | 2 | Offset source: 0 direct, 1 index port 0, 2 index port 1, 3 direct |
| addr | input | 6 | Direct offset within the page |
| wdata | input | 4 | Write data |
| ptr0 | input | 4 | Low offset part for index port 0 |
| ptr1 | input | 2 | High offset part for index port 0 |
| ptr2 | input | 4 | Low offset part for index port 1 |
| ptr3 | input | 2 | High offset part for index port 1 |
| rdata | output | 4 | Read data of the addressed nibble |
| page_o | output | 3 | Current page register value |

## Verification
A corrupted page register shows up on `page_o` in the cycle after the edge that corrupted it. It also shows up on `rdata` at the first paged read after that edge. A wrong offset or page mapping stays hidden until the stray nibble is read back. For that reason the stimulus mixes writes and reads over all pages, all three offset sources and both invalid pages, so a misplaced write tends to be exposed within a few cycles. The bench's reference model is compared on every cycle, so a stale or delayed `rdata` is caught in the first cycle it differs.

// File: rtl/pnr_pkg.sv
package pnr_pkg;
    parameter int DATA_W    = 4;
    parameter int OFF_W     = 6;
    parameter int PAGE_W    = 3;
    parameter int NUM_PAGES = 6;
    parameter int SHARED_N  = 8;

    localparam int HI_W        = OFF_W - DATA_W;
    localparam int PAGE_WORDS  = (1 << OFF_W) - SHARED_N;
    localparam int TOTAL_WORDS = NUM_PAGES * PAGE_WORDS;
    localparam int RAM_IDX_W   = $clog2(TOTAL_WORDS);
    localparam int SH_IDX_W    = $clog2(SHARED_N);

    typedef enum logic [1:0] {
        SEL_DIRECT = 2'd0,
        SEL_IDX0   = 2'd1,
        SEL_IDX1   = 2'd2,
        SEL_ALT    = 2'd3
    } sel_e;

    typedef struct packed {
        logic                 shared_hit;
        logic                 paged_hit;
        logic [SH_IDX_W-1:0]  sh_idx;
        logic [RAM_IDX_W-1:0] ram_idx;
    } target_t;

    typedef struct packed {
        logic [PAGE_W-1:0]                   page;
        logic [SHARED_N-1:0][DATA_W-1:0]     shr;
        logic [TOTAL_WORDS-1:0][DATA_W-1:0]  ram;
    } state_t;
endpackage

// File: rtl/pnr_offset_mux.sv
module pnr_offset_mux
    import pnr_pkg::*;
(
    input  logic [1:0]        sel,
    input  logic [OFF_W-1:0]  addr,
    input  logic [DATA_W-1:0] ptr0,
    input  logic [HI_W-1:0]   ptr1,
    input  logic [DATA_W-1:0] ptr2,
    input  logic [HI_W-1:0]   ptr3,
    output logic [OFF_W-1:0]  off
);
    always_comb begin
        case (sel_e'(sel))
            SEL_IDX0: off = {ptr1, ptr0};
            SEL_IDX1: off = {ptr3, ptr2};
            default:  off = addr;
        endcase
    end
endmodule

// File: rtl/pnr_target_dec.sv
module pnr_target_dec
    import pnr_pkg::*;
(
    input  logic [PAGE_W-1:0] page,
    input  logic [OFF_W-1:0]  off,
    output target_t           tgt
);
    logic page_ok;
    logic in_window;

    assign page_ok   = (page < PAGE_W'(NUM_PAGES));
    assign in_window = (off < OFF_W'(SHARED_N));

    always_comb begin
        tgt = '0;
        if (in_window) begin
            tgt.shared_hit = 1'b1;
            tgt.sh_idx     = off[SH_IDX_W-1:0];
        end else if (page_ok) begin
            tgt.paged_hit = 1'b1;
            tgt.ram_idx   = RAM_IDX_W'(page) * RAM_IDX_W'(PAGE_WORDS)
                          + RAM_IDX_W'(off) - RAM_IDX_W'(SHARED_N);
        end
    end
endmodule

// File: rtl/paged_nibble_ram.sv
module paged_nibble_ram
    import pnr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_ld,
    input  logic [PAGE_W-1:0] page_in,
    input  logic              wr_en,
    input  logic [1:0]        sel,
    input  logic [OFF_W-1:0]  addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] ptr0,
    input  logic [HI_W-1:0]   ptr1,
    input  logic [DATA_W-1:0] ptr2,
    input  logic [HI_W-1:0]   ptr3,
    output logic [DATA_W-1:0] rdata,
    output logic [PAGE_W-1:0] page_o
);
    state_t            st_d, st_q;
    logic [OFF_W-1:0]  off;
    target_t           tgt;

    pnr_offset_mux u_mux (
        .sel  (sel),
        .addr (addr),
        .ptr0 (ptr0),
        .ptr1 (ptr1),
        .ptr2 (ptr2),
        .ptr3 (ptr3),
        .off  (off)
    );

    pnr_target_dec u_dec (
        .page (st_q.page),
        .off  (off),
        .tgt  (tgt)
    );

    // Next-state: page load and write use the page held before this edge.
    always_comb begin
        st_d = st_q;
        if (page_ld) begin
            st_d.page = page_in;
        end
        if (wr_en) begin
            if (tgt.shared_hit) begin
                st_d.shr[tgt.sh_idx] = wdata;
            end else if (tgt.paged_hit) begin
                st_d.ram[tgt.ram_idx] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (tgt.shared_hit) begin
            rdata = st_q.shr[tgt.sh_idx];
        end else if (tgt.paged_hit) begin
            rdata = st_q.ram[tgt.ram_idx];
        end else begin
            rdata = '0;
        end
    end

    assign page_o = st_q.page;
endmodule

// File: rtl/pnr_checker.sv
module pnr_checker
    import pnr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              page_ld,
    input logic [PAGE_W-1:0] page_in,
    input logic              wr_en,
    input logic [1:0]        sel,
    input logic [OFF_W-1:0]  addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [PAGE_W-1:0] page_o
);
    logic direct_sel;
    logic invalid_paged;
    logic direct_ok;

    assign direct_sel    = (sel == 2'd0) || (sel == 2'd3);
    assign invalid_paged = direct_sel && (addr >= OFF_W'(SHARED_N))
                        && (page_o >= PAGE_W'(NUM_PAGES));
    assign direct_ok     = direct_sel && ((addr < OFF_W'(SHARED_N))
                        || (page_o < PAGE_W'(NUM_PAGES)));

    // R1: reset leaves page 0
    a_r1_page_reset: assert property (@(posedge clk)
        !rst_n |=> (page_o == '0));

    // R2: load takes page_in
    a_r2_page_load: assert property (@(posedge clk) disable iff (!rst_n)
        page_ld |=> (page_o == $past(page_in)));

    // R2: page holds without a load
    a_r2_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !page_ld |=> $stable(page_o));

    // R7: invalid page paged reads are zero
    a_r7_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_paged |-> (rdata == '0));

    // R8: a direct write is visible on the next cycle at the same location
    a_r8_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && direct_ok) |=>
        (!(direct_sel && addr == $past(addr) && page_o == $past(page_o))
         || rdata == $past(wdata)));
endmodule

bind paged_nibble_ram pnr_checker u_pnr_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .page_ld (page_ld),
    .page_in (page_in),
    .wr_en   (wr_en),
    .sel     (sel),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .page_o  (page_o)
);

// File: tb/paged_nibble_ram_bench.sv
module paged_nibble_ram_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       page_ld = 1'b0;
    logic [2:0] page_in = '0;
    logic       wr_en = 1'b0;
    logic [1:0] sel = '0;
    logic [5:0] addr = '0;
    logic [3:0] wdata = '0;
    logic [3:0] ptr0 = '0;
    logic [1:0] ptr1 = '0;
    logic [3:0] ptr2 = '0;
    logic [1:0] ptr3 = '0;
    logic [3:0] rdata;
    logic [2:0] page_o;

    int  tests = 0;
    int  fails = 0;
    bit  done = 0;

    int  m_page;
    int  m_shr [8];
    int  m_ram [6][64];

    paged_nibble_ram u_paged_nibble_ram (
        .clk(clk), .rst_n(rst_n), .page_ld(page_ld), .page_in(page_in),
        .wr_en(wr_en), .sel(sel), .addr(addr), .wdata(wdata),
        .ptr0(ptr0), .ptr1(ptr1), .ptr2(ptr2), .ptr3(ptr3),
        .rdata(rdata), .page_o(page_o)
    );

    always #10 clk = ~clk;

    function automatic int eff_off();
        if (sel == 2'd1) return int'(ptr1) * 16 + int'(ptr0);
        if (sel == 2'd2) return int'(ptr3) * 16 + int'(ptr2);
        return int'(addr);
    endfunction

    function automatic int model_read(int off);
        if (off < 8) return m_shr[off];
        if (m_page >= 6) return 0;
        return m_ram[m_page][off];
    endfunction

    function automatic string tag_of(int off);
        if (wr_en) return "R8";
        if (off < 8) return "R3";
        if (m_page >= 6) return "R7";
        if (sel == 2'd1) return "R5";
        if (sel == 2'd2) return "R6";
        return "R4";
    endfunction

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Inputs are set at the falling edge by the caller; compare, then clock.
    task automatic step();
        int off;
        #1;
        off = eff_off();
        check(tag_of(off), int'(rdata), model_read(off));
        check("R2", int'(page_o), m_page);
        @(posedge clk);
        if (wr_en) begin
            if (off < 8) m_shr[off] = int'(wdata);
            else if (m_page < 6) m_ram[m_page][off] = int'(wdata);
        end
        if (page_ld) m_page = int'(page_in);
        @(negedge clk);
    endtask

    task automatic acc(bit we, int s, int a, int d);
        page_ld = 1'b0; wr_en = we; sel = 2'(s); addr = 6'(a); wdata = 4'(d);
        step();
    endtask

    task automatic set_page(int p);
        page_ld = 1'b1; page_in = 3'(p); wr_en = 1'b0; sel = 2'd0;
        step();
        page_ld = 1'b0;
    endtask

    initial begin
        m_page = 0;
        foreach (m_shr[i]) m_shr[i] = 0;
        foreach (m_ram[p, o]) m_ram[p][o] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1", int'(page_o), 0);
        for (int a = 0; a < 64; a += 5) begin
            addr = 6'(a);
            #1 check("R1", int'(rdata), 0);
        end
        @(negedge clk);

        // R4: distinct nibbles per page
        acc(1, 0, 16, 5);
        set_page(3);
        acc(0, 0, 16, 0);
        acc(1, 0, 16, 10);
        acc(0, 0, 16, 0);
        set_page(0);
        acc(0, 0, 16, 0);
        check("R4", int'(rdata), 5);

        // R3: shared window visible from every page, incl. invalid
        set_page(2);
        acc(1, 0, 3, 9);
        set_page(7);
        acc(0, 0, 3, 0);
        check("R3", int'(rdata), 9);

        // R7: invalid page writes ignored, reads zero
        set_page(6);
        acc(1, 0, 40, 15);
        acc(0, 0, 40, 0);
        check("R7", int'(rdata), 0);
        set_page(0);
        acc(0, 0, 40, 0);
        check("R7", int'(rdata), 0);

        // R5 / R6: indexed offsets, address input ignored
        ptr1 = 2'd2; ptr0 = 4'd5;   // offset 37
        ptr3 = 2'd3; ptr2 = 4'd14;  // offset 62
        acc(1, 1, 9, 7);
        acc(1, 2, 9, 12);
        acc(0, 0, 37, 0);
        check("R5", int'(rdata), 7);
        acc(0, 0, 62, 0);
        check("R6", int'(rdata), 12);
        acc(0, 0, 9, 0);
        check("R6", int'(rdata), 0);
        // sel 3 behaves as direct
        acc(0, 3, 37, 0);
        check("R5", int'(rdata), 7);

        // R2: same-cycle load and write uses old page
        page_ld = 1'b1; page_in = 3'd4; wr_en = 1'b1; sel = 2'd0;
        addr = 6'd20; wdata = 4'd6;
        step();
        acc(0, 0, 20, 0);
        check("R2", int'(rdata), 0);
        set_page(0);
        acc(0, 0, 20, 0);
        check("R2", int'(rdata), 6);

        // Mixed stimulus compared every cycle
        for (int i = 0; i < 4000; i++) begin
            page_ld = ($urandom_range(0, 7) == 0);
            page_in = 3'($urandom_range(0, 7));
            wr_en   = ($urandom_range(0, 2) == 0);
            sel     = 2'($urandom_range(0, 3));
            addr    = 6'($urandom_range(0, 63));
            wdata   = 4'($urandom_range(0, 15));
            ptr0    = 4'($urandom_range(0, 15));
            ptr1    = 2'($urandom_range(0, 3));
            ptr2    = 4'($urandom_range(0, 15));
            ptr3    = 2'($urandom_range(0, 3));
            step();
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule